// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block moves received Ethernet frames from a byte stream into memory buffers under the control of a ring of descriptors. Software owns the ring. It marks each descriptor empty and hands it to the engine. The engine reads the descriptor and copies the frame bytes into the buffer that the descriptor points to. It then writes back the byte count and a status word that records ownership, end of frame, address class and receive errors. Reuse is up to software: it clears the slot, marks it empty again, and writes the descriptor-active register to restart polling.

The receive side is a valid/ready byte stream. The engine lowers `rx_ready` whenever it is busy on the memory port, and the MAC must then hold the byte and its flags. When no empty descriptor is available, the engine keeps `rx_ready` high and discards whole frames, so the MAC never blocks. The memory side is a single-request port. A request is held unchanged until `mem_ready`, and read data is taken in the cycle of acceptance. Frame bytes are packed into aligned 32-bit little-endian words with byte enables.

Top module: `rxbd_ring_engine`

## Requirements
- R1: After reset the engine issues no memory request until a descriptor-active write with bit 24 set arrives. Frames offered before that are accepted (`rx_ready` high) and discarded.
- R2: A descriptor-active write with bit 24 clear has no effect on the engine.
- R3: A descriptor is two 32-bit little-endian words. The word at address D holds the length in bits 15:0 and the status in bits 31:16. The word at D+4 holds the buffer pointer. Descriptor k sits at `ring_base` with its low 4 bits forced to zero, plus 8*k.
- R4: For a descriptor whose status bit 15 (empty) is set, the engine stores frame byte i at buffer address ptr+i. Byte lanes are little-endian and writes use byte enables, so bytes outside the frame are untouched. The low 2 bits of the pointer are ignored.
- R5: Writeback sets the length field to the number of bytes stored in that buffer. This count includes the 4 CRC bytes that the stream carries at the end of each frame. Writeback clears status bit 15 and keeps status bits 14:12 and 10:9 as fetched, which includes the wrap bit 13.
- R6: The descriptor that ends a frame gets status bit 11 set. The flags sampled with the final byte are copied into status: `rx_err[5:0]` to bits 5:0 (5 length violation, 4 non-octet, 3 short, 2 CRC, 1 overrun, 0 truncated), `rx_mcast` to bit 6, `rx_bcast` to bit 7, `rx_miss` to bit 8.
- R7: After a descriptor with status bit 13 set, the next descriptor is the ring base. Otherwise the next descriptor is the following 8-byte slot.
- R8: A frame longer than `max_buf_len` continues into the next descriptor. Every buffer except the last one is written back with length `max_buf_len` and with bits 11 and 8:0 clear.
- R9: A fetched descriptor without the empty bit stops the engine. The current frame, or the rest of it, is discarded, and later frames are discarded too. A later bit-24 write makes the engine re-read the same descriptor once no frame is in progress.
- R10: A byte transfers only when `rx_valid` and `rx_ready` are both high, and `rx_last` marks the final byte of a frame. `rx_ready` is low while a memory request is pending.
- R11: Every memory address is word aligned. A request that is not accepted stays stable until `mem_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_base | input | ADDR_W | Ring start address (low 4 bits ignored) |
| max_buf_len | input | 16 | Bytes per receive buffer |
| desc_active_wr | input | 1 | Write strobe of the descriptor-active register |
| desc_active_wdata | input | 32 | Write data; bit 24 restarts polling |
| rx_valid | input | 1 | Stream byte valid |
| rx_ready | output | 1 | Engine can take a byte |
| rx_data | input | 8 | Stream byte |
| rx_last | input | 1 | Final byte of the frame |
| rx_err | input | 6 | Error flags, valid with the final byte |
| rx_bcast | input | 1 | Broadcast frame, valid with the final byte |
| rx_mcast | input | 1 | Multicast frame, valid with the final byte |
| rx_miss | input | 1 | Address-filter miss, valid with the final byte |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory request accepted |
| mem_write | output | 1 | 1 for write, 0 for read |
| mem_addr | output | ADDR_W | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Write byte enables |
| mem_rdata | input | 32 | Read data, valid in the accept cycle |

## Verification
A wrong ring offset or a lost wrap bit sends the next writeback to the wrong slot. That shows up as a stale length or status word in memory as soon as the next frame completes. A wrong byte count or packer lane corrupts buffer contents or the length field of that same frame. A stuck ownership or active flag shows at the ports at once: `rx_ready` stays low with no memory traffic, or frames are stored into descriptors that software still owns. The directed scenarios aim at each of these, including a frame that spans two buffers and a restart after a stall.

// File: rtl/rxbd_pkg.sv
package rxbd_pkg;

  // engine states
  typedef enum logic [2:0] {
    ST_IDLE,     // stalled: waiting for a poll request, dropping frames
    ST_RD_STAT,  // reading length/status word
    ST_RD_PTR,   // reading buffer pointer word
    ST_RECV,     // taking stream bytes into the packer
    ST_WR_DATA,  // writing one packed data word
    ST_WR_DESC   // writing back length/status
  } rxbd_state_e;

  localparam int WORD_W      = 32;
  localparam int WORD_BYTES  = WORD_W / 8;
  localparam int LEN_W       = 16;
  localparam int DESC_BYTES  = 8;
  localparam int RING_ALIGN  = 16;
  localparam int ERR_W       = 6;

  // status bit positions decoded by software
  localparam int SB_EMPTY = 15;
  localparam int SB_WRAP  = 13;
  localparam int SB_LAST  = 11;
  localparam int SB_MISS  = 8;
  localparam int SB_BCAST = 7;
  localparam int SB_MCAST = 6;

  // status bits kept from the fetched word on writeback
  localparam logic [LEN_W-1:0] KEEP_MASK = 16'h7600;

endpackage

// File: rtl/rxbd_ring_ptr.sv
module rxbd_ring_ptr import rxbd_pkg::*; #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] ring_base,
  input  logic              advance,
  input  logic              wrap,
  output logic [ADDR_W-1:0] desc_addr
);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(RING_ALIGN - 1);
  localparam logic [ADDR_W-1:0] STEP       = ADDR_W'(DESC_BYTES);

  logic [ADDR_W-1:0] offset_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      offset_q <= '0;
    end else if (advance) begin
      offset_q <= wrap ? '0 : offset_q + STEP;
    end
  end

  assign desc_addr = (ring_base & ALIGN_MASK) + offset_q;
endmodule

// File: rtl/rxbd_byte_packer.sv
module rxbd_byte_packer import rxbd_pkg::*; #(
  parameter int LANES = WORD_BYTES
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     push,
  input  logic [$clog2(LANES)-1:0] lane,
  input  logic [7:0]               byte_in,
  input  logic                     clear,
  output logic [LANES*8-1:0]       word,
  output logic [LANES-1:0]         be
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] data_q;
    logic       en_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        data_q <= '0;
        en_q   <= 1'b0;
      end else if (clear) begin
        en_q <= 1'b0;
      end else if (push && lane == g) begin
        data_q <= byte_in;
        en_q   <= 1'b1;
      end
    end
    assign word[g*8 +: 8] = data_q;
    assign be[g]          = en_q;
  end
endmodule

// File: rtl/rxbd_status_fmt.sv
module rxbd_status_fmt import rxbd_pkg::*; (
  input  logic [LEN_W-1:0] stat_in,
  input  logic             frame_end,
  input  logic [ERR_W-1:0] err,
  input  logic             bcast,
  input  logic             mcast,
  input  logic             miss,
  output logic [LEN_W-1:0] stat_out
);
  always_comb begin
    stat_out = stat_in & KEEP_MASK;
    if (frame_end) begin
      stat_out[SB_LAST]     = 1'b1;
      stat_out[SB_MISS]     = miss;
      stat_out[SB_BCAST]    = bcast;
      stat_out[SB_MCAST]    = mcast;
      stat_out[ERR_W-1:0]   = err;
    end
  end
endmodule

// File: rtl/rxbd_ring_engine.sv
module rxbd_ring_engine import rxbd_pkg::*; #(
  parameter int ADDR_W   = 32,
  parameter int KICK_BIT = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] ring_base,
  input  logic [15:0]       max_buf_len,
  input  logic              desc_active_wr,
  input  logic [31:0]       desc_active_wdata,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [7:0]        rx_data,
  input  logic              rx_last,
  input  logic [5:0]        rx_err,
  input  logic              rx_bcast,
  input  logic              rx_mcast,
  input  logic              rx_miss,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_write,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  output logic [3:0]        mem_be,
  input  logic [31:0]       mem_rdata
);
  localparam int                LANE_W    = $clog2(WORD_BYTES);
  localparam logic [31:0]       KICK_MASK = 32'(1) << KICK_BIT;
  localparam logic [ADDR_W-1:0] PTR_MASK  = ~ADDR_W'(WORD_BYTES - 1);

  rxbd_state_e       st;
  logic              active_q;
  logic              mid_frame_q;
  logic [ADDR_W-1:0] buf_ptr_q;
  logic [LEN_W-1:0]  buf_cnt_q;
  logic [LEN_W-1:0]  stat_q;
  logic              fin_q;
  logic [ERR_W-1:0]  err_q;
  logic              bcast_q, mcast_q, miss_q;

  logic              kick;
  logic              rx_fire;
  logic              mem_fire;
  logic              flush;
  logic              buf_full;
  logic              advance;
  logic [ADDR_W-1:0] desc_addr;
  logic [LEN_W-1:0]  last_idx;
  logic [LEN_W-1:0]  word_off;
  logic [WORD_W-1:0] pack_word;
  logic [WORD_BYTES-1:0] pack_be;
  logic [LEN_W-1:0]  stat_new;

  assign kick     = desc_active_wr && ((desc_active_wdata & KICK_MASK) != '0);
  assign rx_fire  = rx_valid && rx_ready;
  assign mem_fire = mem_valid && mem_ready;
  assign buf_full = (buf_cnt_q == max_buf_len);
  assign flush    = (buf_cnt_q[LANE_W-1:0] == LANE_W'(WORD_BYTES - 1)) || rx_last ||
                    ((buf_cnt_q + 16'd1) == max_buf_len);
  assign advance  = (st == ST_WR_DESC) && mem_fire;
  assign last_idx = buf_cnt_q - 16'd1;
  assign word_off = last_idx & ~LEN_W'(WORD_BYTES - 1);

  // stream acceptance: while filling, or while stalled and not about to leave
  always_comb begin
    case (st)
      ST_RECV: rx_ready = 1'b1;
      ST_IDLE: rx_ready = !(active_q && !mid_frame_q);
      default: rx_ready = 1'b0;
    endcase
  end

  rxbd_ring_ptr #(.ADDR_W(ADDR_W)) u_ring_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .ring_base (ring_base),
    .advance   (advance),
    .wrap      (stat_q[SB_WRAP]),
    .desc_addr (desc_addr)
  );

  rxbd_byte_packer #(.LANES(WORD_BYTES)) u_packer (
    .clk     (clk),
    .rst_n   (rst_n),
    .push    (rx_fire && st == ST_RECV),
    .lane    (buf_cnt_q[LANE_W-1:0]),
    .byte_in (rx_data),
    .clear   ((st == ST_WR_DATA) && mem_fire),
    .word    (pack_word),
    .be      (pack_be)
  );

  rxbd_status_fmt u_status_fmt (
    .stat_in   (stat_q),
    .frame_end (fin_q),
    .err       (err_q),
    .bcast     (bcast_q),
    .mcast     (mcast_q),
    .miss      (miss_q),
    .stat_out  (stat_new)
  );

  // memory request mux
  always_comb begin
    mem_valid = 1'b0;
    mem_write = 1'b0;
    mem_addr  = desc_addr;
    mem_wdata = '0;
    mem_be    = '0;
    case (st)
      ST_RD_STAT: begin
        mem_valid = 1'b1;
      end
      ST_RD_PTR: begin
        mem_valid = 1'b1;
        mem_addr  = desc_addr + ADDR_W'(WORD_BYTES);
      end
      ST_WR_DATA: begin
        mem_valid = 1'b1;
        mem_write = 1'b1;
        mem_addr  = buf_ptr_q + ADDR_W'(word_off);
        mem_wdata = pack_word;
        mem_be    = pack_be;
      end
      ST_WR_DESC: begin
        mem_valid = 1'b1;
        mem_write = 1'b1;
        mem_wdata = {stat_new, buf_cnt_q};
        mem_be    = '1;
      end
      default: ;
    endcase
  end

  // poll request flag: set by a kick, cleared when a fetch finds no empty slot
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
    end else if (kick) begin
      active_q <= 1'b1;
    end else if (st == ST_RD_STAT && mem_fire && !mem_rdata[16 + SB_EMPTY]) begin
      active_q <= 1'b0;
    end
  end

  // frame-in-progress tracking, independent of whether bytes are stored
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mid_frame_q <= 1'b0;
    end else if (rx_fire) begin
      mid_frame_q <= !rx_last;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      buf_ptr_q <= '0;
      buf_cnt_q <= '0;
      stat_q    <= '0;
      fin_q     <= 1'b0;
      err_q     <= '0;
      bcast_q   <= 1'b0;
      mcast_q   <= 1'b0;
      miss_q    <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (active_q && !mid_frame_q) st <= ST_RD_STAT;
        end
        ST_RD_STAT: begin
          if (mem_fire) begin
            if (mem_rdata[16 + SB_EMPTY]) begin
              stat_q <= mem_rdata[31:16];
              st     <= ST_RD_PTR;
            end else begin
              st <= ST_IDLE;
            end
          end
        end
        ST_RD_PTR: begin
          if (mem_fire) begin
            buf_ptr_q <= mem_rdata[ADDR_W-1:0] & PTR_MASK;
            buf_cnt_q <= '0;
            fin_q     <= 1'b0;
            st        <= ST_RECV;
          end
        end
        ST_RECV: begin
          if (rx_fire) begin
            buf_cnt_q <= buf_cnt_q + 16'd1;
            if (rx_last) begin
              fin_q   <= 1'b1;
              err_q   <= rx_err;
              bcast_q <= rx_bcast;
              mcast_q <= rx_mcast;
              miss_q  <= rx_miss;
            end
            if (flush) st <= ST_WR_DATA;
          end
        end
        ST_WR_DATA: begin
          if (mem_fire) begin
            st <= (fin_q || buf_full) ? ST_WR_DESC : ST_RECV;
          end
        end
        ST_WR_DESC: begin
          if (mem_fire) st <= ST_RD_STAT;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rxbd_ring_engine_chk.sv
module rxbd_ring_engine_chk import rxbd_pkg::*; #(
  parameter int ADDR_W   = 32,
  parameter int KICK_BIT = 24
) (
  input logic              clk,
  input logic              rst_n,
  input rxbd_state_e       st,
  input logic [15:0]       max_buf_len,
  input logic              desc_active_wr,
  input logic [31:0]       desc_active_wdata,
  input logic              rx_ready,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic              mem_write,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [31:0]       mem_wdata,
  input logic [3:0]        mem_be
);
  logic seen_kick_q;

  always_ff @(posedge clk) begin
    if (!rst_n) seen_kick_q <= 1'b0;
    else if (desc_active_wr && desc_active_wdata[KICK_BIT]) seen_kick_q <= 1'b1;
  end

  // R1
  quiet_until_kick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_kick_q |-> !mem_valid);

  // R11
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_write) &&
                                   $stable(mem_wdata) && $stable(mem_be)));

  // R11
  mem_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (mem_addr[1:0] == 2'b00));

  // R10
  rx_stall_on_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> !rx_ready);

  // R5
  wb_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WR_DESC && mem_valid) |-> (mem_write && !mem_wdata[31] && mem_be == 4'hF &&
                                         mem_wdata[15:0] != 16'd0));

  // R8
  wb_len_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WR_DESC && mem_valid) |-> (mem_wdata[15:0] <= max_buf_len));
endmodule

bind rxbd_ring_engine rxbd_ring_engine_chk #(.ADDR_W(ADDR_W), .KICK_BIT(KICK_BIT)) u_chk (
  .clk               (clk),
  .rst_n             (rst_n),
  .st                (st),
  .max_buf_len       (max_buf_len),
  .desc_active_wr    (desc_active_wr),
  .desc_active_wdata (desc_active_wdata),
  .rx_ready          (rx_ready),
  .mem_valid         (mem_valid),
  .mem_ready         (mem_ready),
  .mem_write         (mem_write),
  .mem_addr          (mem_addr),
  .mem_wdata         (mem_wdata),
  .mem_be            (mem_be)
);

// File: tb/rxbd_ring_engine_bench.sv
module rxbd_ring_engine_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] ring_base = 32'h0000_0107;
  logic [15:0]   max_buf_len = 16'd64;
  logic          desc_active_wr = 1'b0;
  logic [31:0]   desc_active_wdata = '0;
  logic          rx_valid = 1'b0;
  logic          rx_ready;
  logic [7:0]    rx_data = '0;
  logic          rx_last = 1'b0;
  logic [5:0]    rx_err = '0;
  logic          rx_bcast = 1'b0, rx_mcast = 1'b0, rx_miss = 1'b0;
  logic          mem_valid, mem_write, mem_ready;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_wdata, mem_rdata;
  logic [3:0]    mem_be;

  logic [31:0] mem [0:1023];
  logic [1:0]  rdy_cnt = '0;
  int          acc_cnt = 0;
  int          misalign = 0;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          bp_seen = 1'b0;
  int          bytes_taken = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rxbd_ring_engine #(.ADDR_W(AW)) u_rxbd_ring_engine (
    .clk(clk), .rst_n(rst_n), .ring_base(ring_base), .max_buf_len(max_buf_len),
    .desc_active_wr(desc_active_wr), .desc_active_wdata(desc_active_wdata),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .rx_last(rx_last),
    .rx_err(rx_err), .rx_bcast(rx_bcast), .rx_mcast(rx_mcast), .rx_miss(rx_miss),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_rdata(mem_rdata)
  );

  // memory model: ready three cycles out of four
  assign mem_ready = (rdy_cnt != 2'd0);
  assign mem_rdata = mem[mem_addr[11:2]];

  always @(negedge clk) rdy_cnt <= rdy_cnt + 2'd1;

  always @(posedge clk) begin
    if (rst_n && mem_valid && mem_ready) begin
      acc_cnt <= acc_cnt + 1;
      if (mem_addr[1:0] != 2'b00) misalign <= misalign + 1;
      if (mem_write) begin
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) mem[mem_addr[11:2]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
      end
    end
  end

  function automatic logic [7:0] rd_byte(input int addr);
    return mem[addr >> 2][(addr & 3)*8 +: 8];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic kick(input logic [31:0] val);
    @(negedge clk);
    desc_active_wr    = 1'b1;
    desc_active_wdata = val;
    @(negedge clk);
    desc_active_wr    = 1'b0;
    desc_active_wdata = '0;
  endtask

  task automatic send_frame(input int n, input logic [7:0] first, input logic [5:0] err,
                            input logic bc, input logic mc, input logic ms);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_valid = 1'b1;
      rx_data  = first + 8'(i);
      rx_last  = (i == n - 1);
      rx_err   = (i == n - 1) ? err : 6'h3F;
      rx_bcast = (i == n - 1) ? bc : 1'b0;
      rx_mcast = (i == n - 1) ? mc : 1'b0;
      rx_miss  = (i == n - 1) ? ms : 1'b0;
      while (!rx_ready) begin
        bp_seen = 1'b1;
        @(negedge clk);
      end
      @(posedge clk);
      bytes_taken++;
    end
    @(negedge clk);
    rx_valid = 1'b0;
    rx_last  = 1'b0;
  endtask

  task automatic wait_desc(input int addr);
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (!mem[addr >> 2][31]) break;
    end
    repeat (8) @(negedge clk);
  endtask

  // R1, R2: quiet before the first poll request
  task automatic t_reset_quiet();
    chk("R1 rx_ready after reset", 32'(rx_ready), 32'd1);
    send_frame(6, 8'h11, 6'h0, 1'b0, 1'b0, 1'b0);
    repeat (10) @(negedge clk);
    chk("R1 no memory access before poll", 32'(acc_cnt), 32'd0);
    chk("R1 dropped bytes accepted", 32'(bytes_taken), 32'd6);
    kick(32'h00FF_FFFF);
    repeat (20) @(negedge clk);
    chk("R2 write without bit 24 ignored", 32'(acc_cnt), 32'd0);
  endtask

  // R3, R4, R5, R6: simple frame into descriptor 0
  task automatic t_basic();
    kick(32'h0100_0000);
    send_frame(10, 8'hA0, 6'h0, 1'b1, 1'b0, 1'b0);
    wait_desc(32'h100);
    chk("R3 R5 R6 desc0 writeback", mem[32'h100 >> 2], 32'h0880_000A);
    begin
      logic ok = 1'b1;
      for (int i = 0; i < 10; i++) if (rd_byte(32'h400 + i) !== 8'hA0 + 8'(i)) ok = 1'b0;
      chk("R4 frame bytes in buffer", 32'(ok), 32'd1);
    end
    chk("R4 byte past frame untouched", 32'(rd_byte(32'h40A)), 32'hEE);
  endtask

  // R5, R6: error and class mapping, kept software bits
  task automatic t_errors();
    send_frame(7, 8'h70, 6'h25, 1'b0, 1'b1, 1'b0);
    wait_desc(32'h108);
    chk("R6 R5 desc1 status and length", mem[32'h108 >> 2], 32'h1865_0007);
    chk("R4 desc1 last byte", 32'(rd_byte(32'h506)), 32'h76);
  endtask

  // R7, R9: wrap slot, then stall on the reused base slot and restart
  task automatic t_wrap_stall();
    int snap;
    send_frame(5, 8'h20, 6'h0, 1'b0, 1'b0, 1'b1);
    wait_desc(32'h110);
    chk("R6 R7 desc2 wrap status", mem[32'h110 >> 2], 32'h2900_0005);
    chk("R4 pointer low bits ignored", 32'(rd_byte(32'h600)), 32'h20);
    repeat (20) @(negedge clk);
    snap = acc_cnt;
    bytes_taken = 0;
    send_frame(6, 8'h90, 6'h0, 1'b0, 1'b0, 1'b0);
    repeat (10) @(negedge clk);
    chk("R9 stalled frame dropped, no access", 32'(acc_cnt - snap), 32'd0);
    chk("R9 stalled frame bytes accepted", 32'(bytes_taken), 32'd6);
    chk("R9 desc0 untouched while stalled", mem[32'h100 >> 2], 32'h0880_000A);
    mem[32'h100 >> 2] = 32'h8000_0000;
    kick(32'h0100_0000);
    send_frame(4, 8'h30, 6'h0, 1'b0, 1'b0, 1'b0);
    wait_desc(32'h100);
    chk("R7 R9 refetch after wrap writes desc0", mem[32'h100 >> 2], 32'h0800_0004);
    chk("R7 desc0 buffer reused", 32'(rd_byte(32'h403)), 32'h33);
  endtask

  // R8: frame spanning two buffers
  task automatic t_split();
    repeat (20) @(negedge clk);
    mem[32'h108 >> 2] = 32'h8000_0000;
    mem[32'h110 >> 2] = 32'hA000_0000;
    max_buf_len = 16'd16;
    kick(32'h0100_0000);
    send_frame(20, 8'h50, 6'h02, 1'b1, 1'b0, 1'b0);
    wait_desc(32'h110);
    chk("R8 first buffer full, no last bit", mem[32'h108 >> 2], 32'h0000_0010);
    chk("R8 R6 second buffer ends frame", mem[32'h110 >> 2], 32'h2882_0004);
    begin
      logic ok = 1'b1;
      for (int i = 0; i < 16; i++) if (rd_byte(32'h500 + i) !== 8'h50 + 8'(i)) ok = 1'b0;
      for (int i = 0; i < 4; i++) if (rd_byte(32'h600 + i) !== 8'h60 + 8'(i)) ok = 1'b0;
      chk("R8 bytes across buffers", 32'(ok), 32'd1);
    end
    chk("R10 back-pressure seen during fill", 32'(bp_seen), 32'd1);
    chk("R11 all addresses aligned", 32'(misalign), 32'd0);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 32'hEEEE_EEEE;
    mem[32'h100 >> 2] = 32'h8000_0000;
    mem[32'h104 >> 2] = 32'h0000_0400;
    mem[32'h108 >> 2] = 32'h9000_0000;
    mem[32'h10C >> 2] = 32'h0000_0500;
    mem[32'h110 >> 2] = 32'hA000_0000;
    mem[32'h114 >> 2] = 32'h0000_0602;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_quiet();
    t_basic();
    t_errors();
    t_wrap_stall();
    t_split();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule